// File: doc/BRIEF.md
# Programmable Smart-Pixel Communication Slice

This block is a grid of one-bit pixels placed across a bundle of parallel channels, each channel modelled as a single digital bit. Every pixel sits on exactly one channel. Each pixel passes the channel bit through unchanged, overwrites it with a local data bit, or taps it for local logic. Which of these a pixel does is decided by a small per-pixel configuration word. The word holds a mode and one stored address bit.

Configuration arrives as a serial bit stream through a long shift chain. The stream takes effect for all pixels at once when a load strobe fires. Local data to send enters as one word, with one bit per column. Tapped data leaves as one word, with one bit per column, together with a validity flag. A separate address cycle compares the channel bits seen by the tapping pixels against their stored address bits. The flag is raised only when every one of them agrees. By choosing a suitable pattern of modes, the surrounding system can embed any point-to-point or multicast topology onto the channels.

Top module: `optical_slice`

## Requirements
- R1: While rstN is low and on the first cycle after it rises, chanOut, rxWord, rxValid and cfgError are all zero, and every pixel behaves as pass-through.
- R2: Pixel p sits at row p/COLS and column p%COLS and owns channel bit p. Its configuration is bits [3p+2:3p] of a ROWS*COLS*3-bit chain. Bits [3p+2:3p+1] hold the mode: 00 pass, 01 send, 10 take, 11 pass. Bit [3p] holds the address bit. The chain shifts toward higher indices, so the first bit shifted in ends up in bit [3*ROWS*COLS-1].
- R3: The chain advances by one bit on each clock where cfgShift is high. The configuration in use is replaced with the whole chain contents in the cycle where cfgLoad is high, and it never changes otherwise. If both strobes are high together, the load uses the chain contents from before that shift.
- R4: For a pixel in pass mode (00 or 11), chanOut[p] one cycle later equals chanIn[p].
- R5: For a pixel in send mode, chanOut[p] one cycle later equals txWord[p%COLS].
- R6: A pixel in take mode still forwards chanIn[p] to chanOut[p] one cycle later. rxWord[c] one cycle later is the OR of chanIn over all take pixels of column c, and it is 0 for a column without take pixels.
- R7: On a cycle with addrPhase high (and cfgLoad low), rxValid one cycle later becomes 1 only if every take pixel's chanIn equals its address bit. With no take pixels at all, it becomes 1. Otherwise it becomes 0. rxValid then holds until the next addrPhase or cfgLoad cycle.
- R8: A cycle with cfgLoad high forces rxValid to 0 one cycle later. This overrides an addrPhase in the same cycle.
- R9: cfgError is high exactly while the configuration in use has two or more take pixels in some column.
- R10: Shifting the chain without a load leaves chanOut, rxWord, rxValid and cfgError following the previous configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanIn | input | ROWS*COLS | Incoming channel bits, one per pixel |
| chanOut | output | ROWS*COLS | Registered outgoing channel bits |
| txWord | input | COLS | Local data to send, one bit per column |
| rxWord | output | COLS | Registered tapped data, one bit per column |
| rxValid | output | 1 | Address match flag of the last address cycle |
| cfgIn | input | 1 | Serial configuration bit |
| cfgShift | input | 1 | Advance the configuration chain |
| cfgLoad | input | 1 | Apply the chain as the active configuration |
| addrPhase | input | 1 | Marks an address comparison cycle |
| cfgError | output | 1 | More than one take pixel in a column |

## Verification
The assertions assume that every input is a defined 0 or 1 at each clock edge. They also assume that configuration changes reach the array only through the load strobe. They place no limit on how many take pixels a column holds, so the OR-combination and the error flag are both checked under deliberately doubled receivers. The stimulus drives all inputs on the falling edge from seeded random values, mostly with at most one receiver per column. It adds directed configurations that stack two receivers in one column and that raise load and address strobes together.

// File: rtl/slice_pkg.sv
`timescale 1ns/1ps
package slice_pkg;

  localparam int CFG_BITS = 3;

  localparam logic [1:0] MODE_PASS = 2'b00;
  localparam logic [1:0] MODE_SEND = 2'b01;
  localparam logic [1:0] MODE_TAKE = 2'b10;
  localparam logic [1:0] MODE_RSVD = 2'b11;

  // strobes from control to datapath
  typedef struct packed {
    logic addrSample;
    logic matchClear;
  } dpStrobe_t;

endpackage

// File: rtl/slice_pixel.sv
`timescale 1ns/1ps
module slice_pixel
  import slice_pkg::*;
(
  input  logic       chIn,
  input  logic       txBit,
  input  logic       addrBit,
  input  logic [1:0] modeBits,
  output logic       nextOut,
  output logic       capBit,
  output logic       isRx,
  output logic       addrOk
);

  logic isTx;

  always_comb begin
    isTx    = (modeBits == MODE_SEND);
    isRx    = (modeBits == MODE_TAKE);
    // outgoing mux: local bit or channel bit (reserved code acts as pass)
    nextOut = isTx ? txBit : chIn;
    // extraction mux toward the column line
    capBit  = isRx ? chIn : 1'b0;
    // comparator only matters for receiving pixels
    addrOk  = ~isRx | (chIn ~^ addrBit);
  end

endmodule

// File: rtl/slice_ctrl.sv
`timescale 1ns/1ps
module slice_ctrl
  import slice_pkg::*;
#(
  parameter int NPIX = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgIn,
  input  logic                     cfgShift,
  input  logic                     cfgLoad,
  input  logic                     addrPhase,
  output logic [NPIX*CFG_BITS-1:0] activeCfg,
  output dpStrobe_t                strobe
);

  localparam int CHAIN = NPIX * CFG_BITS;

  logic [CHAIN-1:0] chainReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chainReg  <= '0;
      activeCfg <= '0;
    end else begin
      if (cfgShift) chainReg <= {chainReg[CHAIN-2:0], cfgIn};
      if (cfgLoad)  activeCfg <= chainReg;
    end
  end

  always_comb begin
    strobe.matchClear = cfgLoad;
    strobe.addrSample = addrPhase & ~cfgLoad;
  end

endmodule

// File: rtl/slice_datapath.sv
`timescale 1ns/1ps
module slice_datapath
  import slice_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [ROWS*COLS-1:0]          chanIn,
  input  logic [COLS-1:0]               txWord,
  input  logic [ROWS*COLS*CFG_BITS-1:0] activeCfg,
  input  dpStrobe_t                     strobe,
  output logic [ROWS*COLS-1:0]          chanOut,
  output logic [COLS-1:0]               rxWord,
  output logic                          rxValid,
  output logic                          cfgError,
  output logic [COLS-1:0]               colHasRx
);

  localparam int NPIX = ROWS * COLS;

  logic [NPIX-1:0] nextOut;
  logic [NPIX-1:0] capBit;
  logic [NPIX-1:0] isRx;
  logic [NPIX-1:0] addrOk;
  logic [COLS-1:0] colCap;
  logic [COLS-1:0] colMulti;
  logic            allMatch;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int P = r * COLS + c;
      slice_pixel u_pix (
        .chIn    (chanIn[P]),
        .txBit   (txWord[c]),
        .addrBit (activeCfg[CFG_BITS*P]),
        .modeBits(activeCfg[CFG_BITS*P+1 +: 2]),
        .nextOut (nextOut[P]),
        .capBit  (capBit[P]),
        .isRx    (isRx[P]),
        .addrOk  (addrOk[P])
      );
    end
  end

  // column combine and duplicate-receiver detection
  always_comb begin
    colCap   = '0;
    colHasRx = '0;
    colMulti = '0;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        colCap[c]   = colCap[c] | capBit[r*COLS+c];
        colMulti[c] = colMulti[c] | (colHasRx[c] & isRx[r*COLS+c]);
        colHasRx[c] = colHasRx[c] | isRx[r*COLS+c];
      end
    end
    cfgError = |colMulti;
    allMatch = &addrOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanOut <= '0;
      rxWord  <= '0;
      rxValid <= 1'b0;
    end else begin
      chanOut <= nextOut;
      rxWord  <= colCap;
      if (strobe.matchClear)      rxValid <= 1'b0;
      else if (strobe.addrSample) rxValid <= allMatch;
    end
  end

endmodule

// File: rtl/optical_slice.sv
`timescale 1ns/1ps
module optical_slice
  import slice_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ROWS*COLS-1:0] chanIn,
  output logic [ROWS*COLS-1:0] chanOut,
  input  logic [COLS-1:0]      txWord,
  output logic [COLS-1:0]      rxWord,
  output logic                 rxValid,
  input  logic                 cfgIn,
  input  logic                 cfgShift,
  input  logic                 cfgLoad,
  input  logic                 addrPhase,
  output logic                 cfgError
);

  localparam int NPIX = ROWS * COLS;

  logic [NPIX*CFG_BITS-1:0] activeCfg;
  logic [COLS-1:0]          colHasRx;
  dpStrobe_t                strobe;

  slice_ctrl #(.NPIX(NPIX)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgIn    (cfgIn),
    .cfgShift (cfgShift),
    .cfgLoad  (cfgLoad),
    .addrPhase(addrPhase),
    .activeCfg(activeCfg),
    .strobe   (strobe)
  );

  slice_datapath #(.ROWS(ROWS), .COLS(COLS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .chanIn   (chanIn),
    .txWord   (txWord),
    .activeCfg(activeCfg),
    .strobe   (strobe),
    .chanOut  (chanOut),
    .rxWord   (rxWord),
    .rxValid  (rxValid),
    .cfgError (cfgError),
    .colHasRx (colHasRx)
  );

endmodule

// File: rtl/slice_checks.sv
`timescale 1ns/1ps
module slice_checks #(
  parameter int ROWS = 4,
  parameter int COLS = 8
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [ROWS*COLS-1:0]   chanIn,
  input logic [COLS-1:0]        txWord,
  input logic [ROWS*COLS-1:0]   chanOut,
  input logic [COLS-1:0]        rxWord,
  input logic                   rxValid,
  input logic                   cfgLoad,
  input logic                   addrPhase,
  input logic [ROWS*COLS*3-1:0] activeCfg,
  input logic [COLS-1:0]        colHasRx
);

  p_load_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoad |=> !rxValid);

  p_valid_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgLoad && !addrPhase) |=> $stable(rxValid));

  p_cfg_steady_r3: assert property (@(posedge clk) disable iff (!rstN)
    !cfgLoad |=> $stable(activeCfg));

  for (genvar c = 0; c < COLS; c++) begin : g_colChk
    p_idle_column_r6: assert property (@(posedge clk) disable iff (!rstN)
      !colHasRx[c] |=> !rxWord[c]);
  end

  for (genvar p = 0; p < ROWS*COLS; p++) begin : g_pixChk
    p_send_path_r5: assert property (@(posedge clk) disable iff (!rstN)
      (activeCfg[3*p+1 +: 2] == 2'b01) |=> (chanOut[p] == $past(txWord[p % COLS])));
    p_pass_path_r4: assert property (@(posedge clk) disable iff (!rstN)
      (activeCfg[3*p+1 +: 2] != 2'b01) |=> (chanOut[p] == $past(chanIn[p])));
  end

endmodule

bind optical_slice slice_checks #(.ROWS(ROWS), .COLS(COLS)) u_checks (.*);

// File: tb/tb_optical_slice.sv
`timescale 1ns/1ps
module tb_optical_slice;

  localparam int ROWS = 4;
  localparam int COLS = 8;
  localparam int NCH  = ROWS * COLS;
  localparam int W    = NCH * 3;

  logic           clk = 1'b0;
  logic           rstN;
  logic [NCH-1:0] chanIn;
  logic [NCH-1:0] chanOut;
  logic [COLS-1:0] txWord;
  logic [COLS-1:0] rxWord;
  logic           rxValid;
  logic           cfgIn, cfgShift, cfgLoad, addrPhase;
  logic           cfgError;

  int errors = 0;
  int checks = 0;

  logic [W-1:0] cfgModel = '0;
  logic [W-1:0] chainModel = '0;
  logic         expValid = 1'b0;

  always #4 clk = ~clk;

  optical_slice #(.ROWS(ROWS), .COLS(COLS)) dut (
    .clk(clk), .rstN(rstN), .chanIn(chanIn), .chanOut(chanOut),
    .txWord(txWord), .rxWord(rxWord), .rxValid(rxValid),
    .cfgIn(cfgIn), .cfgShift(cfgShift), .cfgLoad(cfgLoad),
    .addrPhase(addrPhase), .cfgError(cfgError)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] modeOf(input logic [W-1:0] cfg, input int p);
    return cfg[3*p+1 +: 2];
  endfunction

  function automatic logic [NCH-1:0] mOut(input logic [W-1:0] cfg, input logic [NCH-1:0] ci, input logic [COLS-1:0] tx);
    logic [NCH-1:0] o;
    for (int p = 0; p < NCH; p++) o[p] = (modeOf(cfg, p) == 2'b01) ? tx[p % COLS] : ci[p];
    return o;
  endfunction

  function automatic logic [COLS-1:0] mRx(input logic [W-1:0] cfg, input logic [NCH-1:0] ci);
    logic [COLS-1:0] r = '0;
    for (int p = 0; p < NCH; p++) if (modeOf(cfg, p) == 2'b10) r[p % COLS] |= ci[p];
    return r;
  endfunction

  function automatic logic mMatch(input logic [W-1:0] cfg, input logic [NCH-1:0] ci);
    logic ok = 1'b1;
    for (int p = 0; p < NCH; p++) if (modeOf(cfg, p) == 2'b10 && ci[p] != cfg[3*p]) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic mErr(input logic [W-1:0] cfg);
    int cnt [COLS];
    logic e = 1'b0;
    for (int c = 0; c < COLS; c++) cnt[c] = 0;
    for (int p = 0; p < NCH; p++) if (modeOf(cfg, p) == 2'b10) cnt[p % COLS]++;
    for (int c = 0; c < COLS; c++) if (cnt[c] > 1) e = 1'b1;
    return e;
  endfunction

  // one clock: drive at the falling edge, check at the next falling edge
  task automatic cycle(input logic [NCH-1:0] ci, input logic [COLS-1:0] tx, input logic ap,
                       input logic sh, input logic sb, input logic ld, input string ctx);
    logic [NCH-1:0]  eOut;
    logic [COLS-1:0] eRx;
    chanIn = ci; txWord = tx; addrPhase = ap; cfgShift = sh; cfgIn = sb; cfgLoad = ld;
    eOut = mOut(cfgModel, ci, tx);
    eRx  = mRx(cfgModel, ci);
    if (ld)      expValid = 1'b0;
    else if (ap) expValid = mMatch(cfgModel, ci);
    if (ld) cfgModel = chainModel;
    if (sh) chainModel = {chainModel[W-2:0], sb};
    @(negedge clk);
    check(chanOut == eOut, {"R4 R5 chanOut ", ctx}, 64'(chanOut), 64'(eOut));
    check(rxWord == eRx, {"R6 rxWord ", ctx}, 64'(rxWord), 64'(eRx));
    check(rxValid == expValid, {"R7 R8 rxValid ", ctx}, 64'(rxValid), 64'(expValid));
    check(cfgError == mErr(cfgModel), {"R9 cfgError ", ctx}, 64'(cfgError), 64'(mErr(cfgModel)));
  endtask

  // shift a full word (R2 ordering: top bit first), then load (R3)
  task automatic loadCfg(input logic [W-1:0] cfg, input string ctx);
    logic [NCH-1:0] ci = {$urandom, $urandom};
    for (int i = W - 1; i >= 0; i--) cycle(ci, COLS'($urandom), 1'b0, 1'b1, cfg[i], 1'b0, {"R10 R2 shift ", ctx});
    cycle(ci, COLS'($urandom), 1'b0, 1'b0, 1'b0, 1'b1, {"R3 load ", ctx});
  endtask

  task automatic dataRun(input int n, input string ctx);
    for (int i = 0; i < n; i++)
      cycle({$urandom, $urandom}, COLS'($urandom), ($urandom % 5) == 0, 1'b0, 1'b0, 1'b0, ctx);
  endtask

  function automatic logic [W-1:0] randCfg();
    logic [W-1:0] cfg;
    for (int p = 0; p < NCH; p++) begin
      logic [1:0] m;
      case ($urandom % 3)
        0: m = 2'b00;
        1: m = 2'b01;
        default: m = 2'b11;
      endcase
      cfg[3*p+1 +: 2] = m;
      cfg[3*p] = 1'($urandom);
    end
    for (int c = 0; c < COLS; c++) if ($urandom % 2) cfg[3*(($urandom % ROWS)*COLS + c)+1 +: 2] = 2'b10;
    return cfg;
  endfunction

  initial begin
    #1200000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] cfg;
    logic [NCH-1:0] ci;
    void'($urandom(32'd4242));
    rstN = 1'b0; chanIn = '1; txWord = '1; cfgIn = 1'b1; cfgShift = 1'b1; cfgLoad = 1'b1; addrPhase = 1'b1;
    repeat (3) @(negedge clk);
    check(chanOut == '0 && rxWord == '0 && !rxValid && !cfgError, "R1 reset outputs",
          64'({chanOut, rxWord, rxValid, cfgError}), 64'd0);
    rstN = 1'b1;
    chainModel = '0; cfgModel = '0; expValid = 1'b0;
    cycle('1, '0, 1'b0, 1'b0, 1'b0, 1'b0, "R1 first cycle pass");

    // directed: receiver r0c0 addr 1, sender r1c1, reserved code on r0c2
    cfg = '0;
    cfg[1 +: 2] = 2'b10; cfg[0] = 1'b1;
    cfg[3*(COLS+1)+1 +: 2] = 2'b01;
    cfg[3*2+1 +: 2] = 2'b11;
    loadCfg(cfg, "directed A");
    ci = '0; ci[0] = 1'b1;
    cycle(ci, 8'hA5, 1'b1, 1'b0, 1'b0, 1'b0, "R7 match");
    cycle('0, 8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, "R7 hold");
    cycle('0, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, "R7 mismatch");
    dataRun(10, "R4 R5 R6 directed A");
    // load together with a matching address cycle
    cycle(ci, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R7 rematch");
    cycle(ci, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, "R8 load beats addr");

    // no receivers at all: address cycle is vacuously valid
    loadCfg('0, "no receivers");
    cycle({$urandom, $urandom}, 8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, "R7 vacuous");

    // two receivers in column 3
    cfg = '0;
    cfg[3*3+1 +: 2] = 2'b10;
    cfg[3*(2*COLS+3)+1 +: 2] = 2'b10;
    loadCfg(cfg, "R9 double");
    ci = '0; ci[2*COLS+3] = 1'b1;
    cycle(ci, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R6 column OR");
    dataRun(8, "R9 R6 double");

    // random configurations and traffic
    for (int k = 0; k < 6; k++) begin
      loadCfg(randCfg(), "random");
      dataRun(40, "random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule